// File: doc/BRIEF.md
# Run-Time Configurable Serial Frame Transmitter and Receiver

This block turns parallel words into asynchronous serial frames and turns serial frames back into words, using a frame layout that is chosen while the chip runs. A frame opens with a single low start bit. Between five and nine data bits follow, least significant first. An even or odd parity bit may come next, and the frame closes with one or two high stop bits. Every mix of these settings is legal, which gives thirty formats. The line rests high between frames.

Bit timing comes from outside. A one-cycle `bit_tick` strobe marks each bit boundary. It may come from a baud divider or from the strobes of a synchronous clock engine. The transmitter drives one new bit level per tick. The receiver takes one sample of `rxd` per tick. A word is handed to the transmitter with a valid/ready handshake. The receiver raises a one-cycle valid pulse with the word and two error flags. Each side captures the format settings when its frame begins, so changing the settings in the middle of a frame is harmless.

Top module: `usart_frame_core`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high and `rx_valid`, `rx_parity_err` and `rx_frame_err` are low.
- R2: A word is taken when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` then stays low until the last stop bit has lasted a full tick interval.
- R3: On the first tick after a word is taken, `txd` goes low for the start bit. The data bits follow, least significant first. The length code `cfg_len` selects 5, 6, 7, 8 or 9 bits for codes 0 to 4, and codes 5 to 7 also select 9 bits. `txd` is never low while `tx_ready` is high.
- R4: `cfg_par` selects the parity: 2'b01 even, 2'b10 odd, 2'b00 or 2'b11 none. With even parity, the parity bit makes the number of ones across the data and parity bits even. With odd parity it makes that number odd. The parity bit comes straight after the last data bit.
- R5: The transmitter sends two high stop bits when `cfg_two_stop` is 1 and one stop bit when it is 0.
- R6: `tx_data` bits at or above the selected length do not change the serial frame.
- R7: The receiver recognises a low sample at a tick while idle as a start bit. It then samples one bit per tick and, in the cycle after it samples the first stop bit, pulses `rx_valid` for one cycle with the word on `rx_data`. Bits of `rx_data` at or above the selected length read zero.
- R8: `rx_parity_err` goes high together with `rx_valid` when parity is enabled and the received parity bit does not match the data.
- R9: `rx_frame_err` goes high together with `rx_valid` when the first stop bit is sampled low, whatever stop count is set.
- R10: Each side captures `cfg_len`, `cfg_par` and `cfg_two_stop` when its frame begins. Changes to these inputs later in the frame do not affect that frame.
- R11: `txd` changes only in the cycle after a `bit_tick`, so every bit lasts a whole tick interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit boundary |
| cfg_len | input | 3 | Data length code (0..4 give 5..9 bits) |
| cfg_par | input | 2 | Parity mode: 01 even, 10 odd, otherwise none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Transmitter can take a word |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rx_data | output | 9 | Last received word, zero above the length |
| rx_valid | output | 1 | One-cycle pulse for a received word |
| rx_parity_err | output | 1 | Parity mismatch, valid with rx_valid |
| rx_frame_err | output | 1 | First stop bit low, valid with rx_valid |

## Verification
The hardest case to reach is a corrupted frame, because a correct transmitter never sends a wrong parity bit or a low stop bit. The bench therefore disconnects the loopback and drives `rxd` directly, one bit level per tick interval, to build frames with a flipped parity bit or a low first stop bit. The test of settings changed mid-frame also needs care. It waits until the receiver has seen the start bit before it changes the settings, so that both sides have already captured the original format.

// File: rtl/usart_frame_pkg.sv
package usart_frame_pkg;

    localparam int DATA_MAX = 9;
    localparam int CNT_W    = $clog2(DATA_MAX + 1);
    localparam int LEN_W    = 3;
    localparam int MIN_BITS = 5;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_WAIT, TX_DATA, TX_PAR, TX_STOP, TX_STOP2, TX_TAIL
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    // Length code to data-bit count; codes beyond the top one saturate.
    function automatic logic [CNT_W-1:0] bits_from_code(input logic [LEN_W-1:0] code);
        if (int'(code) >= DATA_MAX - MIN_BITS)
            return CNT_W'(DATA_MAX);
        return CNT_W'(code) + CNT_W'(MIN_BITS);
    endfunction

    function automatic logic [DATA_MAX-1:0] data_mask(input logic [CNT_W-1:0] n);
        return {DATA_MAX{1'b1}} >> (DATA_MAX - int'(n));
    endfunction

    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/usart_tx_frame.sv
module usart_tx_frame
    import usart_frame_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_two_stop,
    input  logic [DATA_MAX-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                txd
);

    typedef struct packed {
        tx_state_e           st;
        logic [DATA_MAX-1:0] shift;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    nbits;
        logic                par_en;
        logic                par_bit;
        logic                two_stop;
        logic                line;
    } tx_regs_t;

    tx_regs_t tx_q, tx_d;
    logic [CNT_W-1:0]    len_now;
    logic [DATA_MAX-1:0] word_now;

    always_comb begin
        tx_d     = tx_q;
        len_now  = bits_from_code(cfg_len);
        word_now = tx_data & data_mask(len_now);
        unique case (tx_q.st)
            TX_IDLE: begin
                if (tx_valid) begin
                    tx_d.shift    = word_now;
                    tx_d.nbits    = len_now;
                    tx_d.par_en   = parity_on(cfg_par);
                    tx_d.par_bit  = (^word_now) ^ (cfg_par == PAR_ODD);
                    tx_d.two_stop = cfg_two_stop;
                    tx_d.st       = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (bit_tick) begin
                    tx_d.line = 1'b0;
                    tx_d.cnt  = '0;
                    tx_d.st   = TX_DATA;
                end
            end
            TX_DATA: begin
                if (bit_tick) begin
                    tx_d.line  = tx_q.shift[0];
                    tx_d.shift = tx_q.shift >> 1;
                    tx_d.cnt   = tx_q.cnt + CNT_W'(1);
                    if (tx_q.cnt == tx_q.nbits - CNT_W'(1))
                        tx_d.st = tx_q.par_en ? TX_PAR : TX_STOP;
                end
            end
            TX_PAR: begin
                if (bit_tick) begin
                    tx_d.line = tx_q.par_bit;
                    tx_d.st   = TX_STOP;
                end
            end
            TX_STOP: begin
                if (bit_tick) begin
                    tx_d.line = 1'b1;
                    tx_d.st   = tx_q.two_stop ? TX_STOP2 : TX_TAIL;
                end
            end
            TX_STOP2: begin
                if (bit_tick) begin
                    tx_d.line = 1'b1;
                    tx_d.st   = TX_TAIL;
                end
            end
            TX_TAIL: begin
                if (bit_tick)
                    tx_d.st = TX_IDLE;
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= '0;
            tx_q.st   <= TX_IDLE;
            tx_q.line <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_ready = (tx_q.st == TX_IDLE);
    assign txd      = tx_q.line;

endmodule

// File: rtl/usart_rx_frame.sv
module usart_rx_frame
    import usart_frame_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                rxd,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_parity_err,
    output logic                rx_frame_err
);

    typedef struct packed {
        rx_state_e           st;
        logic [DATA_MAX-1:0] shift;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    nbits;
        logic                par_en;
        logic                odd;
        logic                ones;
        logic                par_bad;
        logic [DATA_MAX-1:0] word;
        logic                valid;
        logic                pe;
        logic                fe;
    } rx_regs_t;

    rx_regs_t rx_q, rx_d;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.pe    = 1'b0;
        rx_d.fe    = 1'b0;
        unique case (rx_q.st)
            RX_IDLE: begin
                if (bit_tick && !rxd) begin
                    rx_d.nbits   = bits_from_code(cfg_len);
                    rx_d.par_en  = parity_on(cfg_par);
                    rx_d.odd     = (cfg_par == PAR_ODD);
                    rx_d.shift   = '0;
                    rx_d.cnt     = '0;
                    rx_d.ones    = 1'b0;
                    rx_d.par_bad = 1'b0;
                    rx_d.st      = RX_DATA;
                end
            end
            RX_DATA: begin
                if (bit_tick) begin
                    rx_d.shift[rx_q.cnt] = rxd;
                    rx_d.ones = rx_q.ones ^ rxd;
                    rx_d.cnt  = rx_q.cnt + CNT_W'(1);
                    if (rx_q.cnt == rx_q.nbits - CNT_W'(1))
                        rx_d.st = rx_q.par_en ? RX_PAR : RX_STOP;
                end
            end
            RX_PAR: begin
                if (bit_tick) begin
                    rx_d.par_bad = rx_q.ones ^ rxd ^ rx_q.odd;
                    rx_d.st      = RX_STOP;
                end
            end
            RX_STOP: begin
                if (bit_tick) begin
                    rx_d.word  = rx_q.shift;
                    rx_d.valid = 1'b1;
                    rx_d.pe    = rx_q.par_bad;
                    rx_d.fe    = !rxd;
                    rx_d.st    = RX_IDLE;
                end
            end
            default: rx_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_q.st <= RX_IDLE;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data       = rx_q.word;
    assign rx_valid      = rx_q.valid;
    assign rx_parity_err = rx_q.pe;
    assign rx_frame_err  = rx_q.fe;

endmodule

// File: rtl/usart_frame_core.sv
module usart_frame_core
    import usart_frame_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_two_stop,
    input  logic [DATA_MAX-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                txd,
    input  logic                rxd,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_parity_err,
    output logic                rx_frame_err
);

    usart_tx_frame tx_u (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .cfg_len      (cfg_len),
        .cfg_par      (cfg_par),
        .cfg_two_stop (cfg_two_stop),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .txd          (txd)
    );

    usart_rx_frame rx_u (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .cfg_len       (cfg_len),
        .cfg_par       (cfg_par),
        .rxd           (rxd),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err)
    );

endmodule

// File: rtl/usart_frame_chk.sv
module usart_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic rx_valid,
    input logic rx_parity_err,
    input logic rx_frame_err
);

    // R11
    txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(txd));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R3
    low_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> !tx_ready);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_parity_err |-> rx_valid);

    // R9
    ferr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_valid);

endmodule

bind usart_frame_core usart_frame_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .txd           (txd),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err)
);

// File: tb/usart_frame_core_tb.sv
`timescale 1ns/1ps
module usart_frame_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [2:0] cfg_len = 3'd3;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       rxd;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       rx_parity_err;
    logic       rx_frame_err;

    logic       loop_en = 1'b1;
    logic       rxd_drv = 1'b1;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;
    int         rx_cnt = 0;
    logic [8:0] rx_got = '0;
    logic       pe_got = 1'b0;
    logic       fe_got = 1'b0;
    logic [1:0] tick_cnt = '0;

    assign rxd = loop_en ? txd : rxd_drv;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tick_cnt <= tick_cnt + 2'd1;
        bit_tick <= (tick_cnt == 2'd2);
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt = rx_cnt + 1;
            rx_got = rx_data;
            pe_got = rx_parity_err;
            fe_got = rx_frame_err;
        end
    end

    usart_frame_core dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .cfg_len       (cfg_len),
        .cfg_par       (cfg_par),
        .cfg_two_stop  (cfg_two_stop),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .txd           (txd),
        .rxd           (rxd),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        while (!bit_tick) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int nbits_of(input logic [2:0] lc);
        return (lc >= 3'd4) ? 9 : int'(lc) + 5;
    endfunction

    // Builds the expected serial frame, bit 0 first on the line.
    function automatic logic [15:0] frame_of(input logic [8:0] data, input logic [2:0] lc,
                                             input logic [1:0] pm, input logic ts, output int len);
        logic [15:0] f = '0;
        int n = nbits_of(lc);
        int k = 1;
        logic p = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[k] = data[i];
            p = p ^ data[i];
            k++;
        end
        if (pm == 2'b01) begin f[k] = p; k++; end
        if (pm == 2'b10) begin f[k] = ~p; k++; end
        f[k] = 1'b1; k++;
        if (ts) begin f[k] = 1'b1; k++; end
        len = k;
        return f;
    endfunction

    function automatic logic [8:0] masked(input logic [8:0] data, input logic [2:0] lc);
        logic [8:0] m = '0;
        for (int i = 0; i < nbits_of(lc); i++) m[i] = data[i];
        return m;
    endfunction

    // Sends one word with loopback on; optionally changes the settings mid-frame.
    task automatic run_frame(input logic [8:0] data, input logic [2:0] lc, input logic [1:0] pm,
                             input logic ts, input string req, input bit alter);
        int len;
        logic [15:0] exp_f;
        logic [15:0] got_f = '0;
        bit stable_ok = 1;
        bit busy_ok = 1;
        exp_f = frame_of(data, lc, pm, ts, len);
        loop_en = 1'b1;
        cfg_len = lc; cfg_par = pm; cfg_two_stop = ts;
        @(negedge clk);
        rx_cnt = 0;
        tx_data = data; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R2", {15'd0, tx_ready}, 16'd0);
        for (int i = 0; i < len; i++) begin
            wait_tick();
            got_f[i] = txd;
            if (tx_ready) busy_ok = 0;
            if (alter && i == 2) begin
                cfg_len = ~lc; cfg_par = ~pm; cfg_two_stop = ~ts;
                tx_data = ~data;
            end
            while (!bit_tick) @(negedge clk);
            if (txd !== got_f[i]) stable_ok = 0;
        end
        check(got_f == exp_f, req, got_f, exp_f);
        check(stable_ok, "R11", {15'd0, stable_ok}, 16'd1);
        check(busy_ok, "R2", {15'd0, busy_ok}, 16'd1);
        wait_tick();
        wait_tick();
        check(tx_ready == 1'b1 && txd == 1'b1, "R2", {14'd0, tx_ready, txd}, 16'd3);
        check(rx_cnt == 1 && rx_got == masked(data, lc), "R7", {7'd0, rx_got}, {7'd0, masked(data, lc)});
        check(pe_got == 1'b0 && fe_got == 1'b0, "R7", {14'd0, pe_got, fe_got}, 16'd0);
    endtask

    // Drives a hand-built frame onto rxd with loopback off.
    task automatic drive_rx(input logic [15:0] f, input int len);
        loop_en = 1'b0;
        rxd_drv = 1'b1;
        wait_tick();
        rx_cnt = 0;
        for (int i = 0; i < len; i++) begin
            rxd_drv = f[i];
            wait_tick();
        end
        rxd_drv = 1'b1;
        wait_tick();
        wait_tick();
    endtask

    task automatic t_reset();
        check(txd == 1'b1, "R1", {15'd0, txd}, 16'd1);
        check(tx_ready == 1'b1, "R1", {15'd0, tx_ready}, 16'd1);
        check(rx_valid == 1'b0 && rx_parity_err == 1'b0 && rx_frame_err == 1'b0, "R1",
              {13'd0, rx_valid, rx_parity_err, rx_frame_err}, 16'd0);
    endtask

    task automatic t_formats();
        run_frame(9'h0A5, 3'd3, 2'b00, 1'b0, "R3", 0);
        run_frame(9'h1C3, 3'd4, 2'b10, 1'b0, "R4", 0);
        run_frame(9'h05A, 3'd2, 2'b01, 1'b0, "R4", 0);
        run_frame(9'h02D, 3'd1, 2'b10, 1'b1, "R5", 0);
        run_frame(9'h013, 3'd0, 2'b11, 1'b1, "R5", 0);
        run_frame(9'h155, 3'd7, 2'b01, 1'b0, "R3", 0);
    endtask

    task automatic t_upper_ignored();
        run_frame(9'h1F6, 3'd0, 2'b01, 1'b1, "R6", 0);
        run_frame(9'h1E9, 3'd0, 2'b01, 1'b1, "R6", 0);
    endtask

    task automatic t_cfg_latched();
        run_frame(9'h0C9, 3'd3, 2'b01, 1'b0, "R10", 1);
    endtask

    task automatic t_parity_err();
        int len;
        logic [15:0] f;
        cfg_len = 3'd3; cfg_par = 2'b01; cfg_two_stop = 1'b0;
        f = frame_of(9'h00F, 3'd3, 2'b01, 1'b0, len);
        f[9] = ~f[9];
        drive_rx(f, len);
        check(rx_cnt == 1 && pe_got == 1'b1 && fe_got == 1'b0, "R8", {14'd0, pe_got, fe_got}, 16'd2);
        check(rx_got == 9'h00F, "R8", {7'd0, rx_got}, 16'h000F);
        f = frame_of(9'h00F, 3'd3, 2'b01, 1'b0, len);
        drive_rx(f, len);
        check(rx_cnt == 1 && pe_got == 1'b0, "R8", {15'd0, pe_got}, 16'd0);
    endtask

    task automatic t_frame_err();
        int len;
        logic [15:0] f;
        cfg_len = 3'd3; cfg_par = 2'b00; cfg_two_stop = 1'b0;
        f = frame_of(9'h033, 3'd3, 2'b00, 1'b0, len);
        f[9] = 1'b0;
        drive_rx(f, len);
        check(rx_cnt == 1 && fe_got == 1'b1 && pe_got == 1'b0, "R9", {14'd0, pe_got, fe_got}, 16'd1);
        check(rx_got == 9'h033, "R9", {7'd0, rx_got}, 16'h0033);
        cfg_two_stop = 1'b1;
        f = frame_of(9'h0AA, 3'd3, 2'b00, 1'b1, len);
        f[9] = 1'b0;
        drive_rx(f, len - 1);
        check(rx_cnt == 1 && fe_got == 1'b1, "R9", {15'd0, fe_got}, 16'd1);
        loop_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_formats();
        t_upper_ignored();
        t_cfg_latched();
        t_parity_err();
        t_frame_err();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule